// File: doc/BRIEF.md
# Segmented Thermometer Switch Decoder with Spare-Cell Substitution

This block turns each 14-bit sample for a segmented current-steering converter into switch controls for its current cells. The sample's top six bits drive 63 unary data cells through a thermometer code. The next four bits drive 15 unary mid-weight cells, also through a thermometer code. The bottom four bits go straight to binary-weighted cells, delayed so that they line up with the decoded paths. One more unary cell supplies the current for the lower segments, and its control is held on at all times.

A background calibration sequencer measures one top-segment cell at a time. While it does so, it presents an enable and the index of that cell. The block forces the named cell's control to 0 and routes that cell's data bit to a spare-cell output, so the spare carries the cell's share of the signal and conversion goes on without a break. The calibration controls are captured together with the sample they arrive with, so a change of index applies from one whole sample onward. All outputs come from one final register stage and change on the same edge.

Top module: `seg_switch_decoder`

## Requirements
- R1: With substitution inactive, top-segment output k (0..62) is 1 exactly when sample bits [13:8], read as unsigned, are greater than k.
- R2: Mid-segment output k (0..14) is 1 exactly when sample bits [7:4], read as unsigned, are greater than k.
- R3: The binary low outputs equal sample bits [3:0] with no change.
- R4: Every output reflects the inputs presented two rising clock edges earlier, and no output shows a new sample after only one edge.
- R5: When the calibration enable is 1 and the index i is in 0..62, top-segment output i is 0, the spare output equals the value R1 gives for output i, and all other top-segment outputs follow R1.
- R6: When the calibration enable is 0, or the index is 63 (no such cell), the spare output is 0 and all top-segment outputs follow R1.
- R7: The calibration enable and index are paired with the sample presented in the same cycle, so a new index applies to that sample and to none before it.
- R8: The lower-segment cell control is 1 at all times, both during reset and after it.
- R9: A synchronous active-low reset clears the top-segment, mid-segment, binary low and spare outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_i | input | 14 | Input sample, unsigned |
| cal_en_i | input | 1 | Substitution enable from the calibration sequencer |
| cal_idx_i | input | 6 | Index of the top-segment cell under calibration |
| msb_therm_o | output | 63 | Top-segment unary cell controls |
| mid_therm_o | output | 15 | Mid-segment unary cell controls |
| lsb_bin_o | output | 4 | Binary low cell controls |
| spare_o | output | 1 | Spare-cell control that carries the calibrated cell's bit |
| lower_cell_o | output | 1 | Control of the cell feeding the lower segments |

## Verification
Every result is due exactly two rising edges after its inputs are driven: the thermometer codes, the substituted spare bit and the delayed low bits alike. The bench drives inputs on falling edges and streams a vector table. At each falling edge it checks the outputs against the vector driven two falling edges before, then drives the next one, so each check samples the cycle in which that result first shows. A directed step test also checks that one edge after a change the outputs still hold the previous sample.

// File: rtl/seg_switch_pkg.sv
// Package: shared segment widths and derived line counts for the
// segmented switch decoder. Assumes every segment is 1..8 bits wide.
package seg_switch_pkg;
    localparam int MSB_BITS   = 6;
    localparam int MID_BITS   = 4;
    localparam int LSB_BITS   = 4;
    localparam int SAMPLE_W   = MSB_BITS + MID_BITS + LSB_BITS;
    localparam int MSB_LINES  = (1 << MSB_BITS) - 1;
    localparam int MID_LINES  = (1 << MID_BITS) - 1;
    localparam int PIPE_DEPTH = 2;
endpackage

// File: rtl/therm_decoder.sv
// therm_decoder: registered binary-to-thermometer decoder.
// Output line k goes high when the input value is greater than k.
// Assumes IN_W is small enough that 2**IN_W-1 lines are practical.
module therm_decoder #(
    parameter int IN_W  = 6,
    parameter int LINES = (1 << IN_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  bin_i,
    output logic [LINES-1:0] therm_q
);
    logic [LINES-1:0] therm_d;

    // One comparator per output line.
    for (genvar k = 0; k < LINES; k++) begin : g_line
        assign therm_d[k] = (bin_i > IN_W'(k));
    end

    // Register the decoded code (first pipeline stage).
    always_ff @(posedge clk) begin
        if (!rst_n) therm_q <= '0;
        else        therm_q <= therm_d;
    end

    // R1/R2: registered code keeps thermometer shape (ones packed at bit 0).
    p_therm_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((therm_q & (therm_q + 1'b1)) == '0));
endmodule

// File: rtl/pipe_delay.sv
// pipe_delay: fixed-depth register delay line with a chosen reset value.
// Used to align paths that do no decoding with the decoded paths.
// Assumes DEPTH >= 1.
module pipe_delay #(
    parameter int             W       = 4,
    parameter int             DEPTH   = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [DEPTH];

    // Shift the value one stage per clock, loading RST_VAL in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) stg_q[s] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int s = 1; s < DEPTH; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/spare_router.sv
// spare_router: combinational substitution of one unary cell.
// When enabled with an index inside the array, the indexed line's bit
// is moved onto the spare output and the line itself is cleared.
// Out-of-range indices and a low enable leave the code untouched.
module spare_router #(
    parameter int LINES = 63,
    parameter int IDX_W = 6
) (
    input  logic             en_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [LINES-1:0] therm_i,
    output logic [LINES-1:0] therm_o,
    output logic             spare_o
);
    logic idx_ok;

    assign idx_ok = ({1'b0, idx_i} < (IDX_W+1)'(LINES));

    // Move the selected cell's bit to the spare and switch the cell off.
    always_comb begin
        therm_o = therm_i;
        spare_o = 1'b0;
        for (int k = 0; k < LINES; k++) begin
            if (en_i && idx_ok && (idx_i == IDX_W'(k))) begin
                spare_o    = therm_i[k];
                therm_o[k] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/seg_switch_decoder.sv
// seg_switch_decoder: top of the segmented switch decoder.
// Stage 1 decodes the top and mid fields and captures the calibration
// controls with their sample; stage 2 applies spare substitution and
// retimes every output together. The low field and the always-on
// lower-segment control pass through delay lines of equal depth.
module seg_switch_decoder
    import seg_switch_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SAMPLE_W-1:0]  sample_i,
    input  logic                 cal_en_i,
    input  logic [MSB_BITS-1:0]  cal_idx_i,
    output logic [MSB_LINES-1:0] msb_therm_o,
    output logic [MID_LINES-1:0] mid_therm_o,
    output logic [LSB_BITS-1:0]  lsb_bin_o,
    output logic                 spare_o,
    output logic                 lower_cell_o
);
    localparam int MSB_LO = MID_BITS + LSB_BITS;
    localparam int MID_LO = LSB_BITS;
    localparam int CAL_W  = MSB_BITS + 1;

    logic [MSB_BITS-1:0]  msb_field;
    logic [MID_BITS-1:0]  mid_field;
    logic [MSB_LINES-1:0] msb_s1;
    logic [MID_LINES-1:0] mid_s1;
    logic [CAL_W-1:0]     cal_s1;
    logic [MSB_LINES-1:0] msb_routed;
    logic                 spare_routed;

    assign msb_field = sample_i[SAMPLE_W-1:MSB_LO];
    assign mid_field = sample_i[MSB_LO-1:MID_LO];

    therm_decoder #(.IN_W(MSB_BITS), .LINES(MSB_LINES)) u_msb_dec (
        .clk(clk), .rst_n(rst_n), .bin_i(msb_field), .therm_q(msb_s1));

    therm_decoder #(.IN_W(MID_BITS), .LINES(MID_LINES)) u_mid_dec (
        .clk(clk), .rst_n(rst_n), .bin_i(mid_field), .therm_q(mid_s1));

    // Calibration controls travel with their sample through stage 1.
    pipe_delay #(.W(CAL_W), .DEPTH(PIPE_DEPTH-1), .RST_VAL('0)) u_cal_dly (
        .clk(clk), .rst_n(rst_n), .d_i({cal_en_i, cal_idx_i}), .q_o(cal_s1));

    pipe_delay #(.W(LSB_BITS), .DEPTH(PIPE_DEPTH), .RST_VAL('0)) u_lsb_dly (
        .clk(clk), .rst_n(rst_n), .d_i(sample_i[LSB_BITS-1:0]), .q_o(lsb_bin_o));

    pipe_delay #(.W(1), .DEPTH(PIPE_DEPTH), .RST_VAL(1'b1)) u_lower_dly (
        .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(lower_cell_o));

    spare_router #(.LINES(MSB_LINES), .IDX_W(MSB_BITS)) u_router (
        .en_i(cal_s1[CAL_W-1]), .idx_i(cal_s1[MSB_BITS-1:0]),
        .therm_i(msb_s1), .therm_o(msb_routed), .spare_o(spare_routed));

    // Common final stage: all unary and spare controls change together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msb_therm_o <= '0;
            mid_therm_o <= '0;
            spare_o     <= 1'b0;
        end else begin
            msb_therm_o <= msb_routed;
            mid_therm_o <= mid_s1;
            spare_o     <= spare_routed;
        end
    end

    // Edges since reset, saturating at 2, so checks never reach past reset.
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
    end

    // R3/R4: low bits arrive unchanged two edges later.
    p_lsb_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (lsb_bin_o == $past(sample_i[LSB_BITS-1:0], 2)));

    // R1/R4: without substitution the top code holds as many ones as the field value.
    p_msb_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && !$past(cal_en_i, 2)) |->
        ($countones(msb_therm_o) == $past(32'(msb_field), 2)));

    // R6: spare stays off when substitution is disabled.
    p_spare_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && !$past(cal_en_i, 2)) |-> !spare_o);

    // R5/R7: substitution moves a bit, never adds or drops one.
    p_sub_conserve_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && $past(cal_en_i, 2)) |->
        (($countones(msb_therm_o) + 32'(spare_o)) == $past(32'(msb_field), 2)));

    // R8: lower-segment cell stays on once reset has been applied.
    p_lower_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0) |-> lower_cell_o);
endmodule

// File: tb/tb_seg_switch_decoder.sv
module tb_seg_switch_decoder;
    localparam int NV = 12;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [13:0] sample_i;
    logic        cal_en_i;
    logic [5:0]  cal_idx_i;
    logic [62:0] msb_therm_o;
    logic [14:0] mid_therm_o;
    logic [3:0]  lsb_bin_o;
    logic        spare_o;
    logic        lower_cell_o;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    seg_switch_decoder dut (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .cal_en_i(cal_en_i),
        .cal_idx_i(cal_idx_i), .msb_therm_o(msb_therm_o), .mid_therm_o(mid_therm_o),
        .lsb_bin_o(lsb_bin_o), .spare_o(spare_o), .lower_cell_o(lower_cell_o));

    // Vector fields: {sample[13:0], cal enable, cal index[5:0]}
    localparam logic [20:0] VEC [NV] = '{
        {14'h0000, 1'b0, 6'd0},  {14'h3FFF, 1'b0, 6'd0},
        {14'h2A5C, 1'b1, 6'd5},  {14'h2A5C, 1'b1, 6'd60},
        {14'h0100, 1'b1, 6'd0},  {14'h00F0, 1'b1, 6'd0},
        {14'h3FFF, 1'b1, 6'd62}, {14'h3FFF, 1'b1, 6'd63},
        {14'h1234, 1'b0, 6'd17}, {14'h1234, 1'b1, 6'd17},
        {14'h1234, 1'b1, 6'd18}, {14'h0007, 1'b1, 6'd1}};

    function automatic logic [62:0] therm63(input logic [5:0] v);
        logic [62:0] r = '0;
        for (int k = 0; k < 63; k++) r[k] = (int'(v) > k);
        return r;
    endfunction

    function automatic logic [14:0] therm15(input logic [3:0] v);
        logic [14:0] r = '0;
        for (int k = 0; k < 15; k++) r[k] = (int'(v) > k);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Compare all outputs with the model for one {sample, en, idx} vector.
    task automatic check_vec(input logic [20:0] v, input string tag);
        logic [13:0] s = v[20:7];
        logic [62:0] em = therm63(s[13:8]);
        logic        es = 1'b0;
        if (v[6] && v[5:0] != 6'd63) begin   // R5 substitution, R6 otherwise
            es = em[v[5:0]];
            em[v[5:0]] = 1'b0;
        end
        chk(msb_therm_o == em, {tag, " R1/R5 msb"}, 64'(msb_therm_o), 64'(em));
        chk(mid_therm_o == therm15(s[7:4]), {tag, " R2 mid"},
            64'(mid_therm_o), 64'(therm15(s[7:4])));
        chk(lsb_bin_o == s[3:0], {tag, " R3 lsb"}, 64'(lsb_bin_o), 64'(s[3:0]));
        chk(spare_o == es, {tag, " R5/R6 spare"}, 64'(spare_o), 64'(es));
        chk(lower_cell_o == 1'b1, {tag, " R8 lower"}, 64'(lower_cell_o), 64'd1);
    endtask

    task automatic drive(input logic [20:0] v);
        sample_i  = v[20:7];
        cal_en_i  = v[6];
        cal_idx_i = v[5:0];
    endtask

    initial begin : watchdog
        #100000;
        n_err++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0;
        drive({14'h3FFF, 1'b1, 6'd3});
        repeat (4) @(negedge clk);
        // R9 reset clears data outputs; R8 lower cell on during reset
        chk(msb_therm_o == '0, "R9 msb reset", 64'(msb_therm_o), 64'd0);
        chk(mid_therm_o == '0, "R9 mid reset", 64'(mid_therm_o), 64'd0);
        chk(lsb_bin_o == '0, "R9 lsb reset", 64'(lsb_bin_o), 64'd0);
        chk(spare_o == 1'b0, "R9 spare reset", 64'(spare_o), 64'd0);
        chk(lower_cell_o == 1'b1, "R8 lower in reset", 64'(lower_cell_o), 64'd1);
        rst_n = 1'b1;

        // Streamed table: outputs at each falling edge belong to the vector
        // driven two falling edges earlier (R4, R7 index per sample).
        for (int k = 0; k < NV + 2; k++) begin
            @(negedge clk);
            if (k >= 2) check_vec(VEC[k-2], $sformatf("vec%0d R4 R7", k - 2));
            if (k < NV) drive(VEC[k]);
        end

        // R4 step: after one edge the old sample still shows, after two the new.
        drive({14'h0000, 1'b0, 6'd0});
        repeat (3) @(negedge clk);
        drive({14'h3FFF, 1'b1, 6'd0});
        @(negedge clk);
        check_vec({14'h0000, 1'b0, 6'd0}, "step one-edge R4");
        @(negedge clk);
        check_vec({14'h3FFF, 1'b1, 6'd0}, "step two-edge R4");

        // R7: index changes while the sample holds; each sample keeps its own.
        drive({14'h3FFF, 1'b1, 6'd40});
        @(negedge clk);
        drive({14'h3FFF, 1'b1, 6'd41});
        @(negedge clk);
        check_vec({14'h3FFF, 1'b1, 6'd40}, "idx40 R7");
        @(negedge clk);
        check_vec({14'h3FFF, 1'b1, 6'd41}, "idx41 R7");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule